// File: doc/BRIEF.md
# Multiplexed Address/Data Register Bus Master

This block lets an in-band command decoder reach the registers of a PHY device over an 8-bit bus on which address and data share the same wires. Each accepted command performs exactly one single-byte operation: a register read, a register write, or a fixed-length PHY reset pulse. The block produces chip select, an address latch enable, separate read and write strobes, an active-low PHY reset and the shared bus split into output, output-enable and input halves, all timed in whole cycles of the system clock.

A transfer starts with an address phase. Chip select goes low and the address is driven for a setup interval. ALE then goes high for a set number of cycles, and the address is held for a further interval after ALE falls. For a read the block releases the bus and pulls the read strobe low; the byte present in the last strobe cycle is captured. For a write the data byte is driven through the write strobe and held for one cycle after the strobe rises. A single-cycle `done` pulse ends every command, and `busy` covers the time in between. The PHY interrupt input is passed through a synchronizer so the command logic can read it as `irq_level`.

Top module: `phy_mbus_master`

## Requirements
- R1: While `rst_n` is low, and at once when it is asserted in the middle of a transfer, `mb_cs_n`, `mb_rd_n`, `mb_wr_n` and `phy_rst_n` are high, and `mb_ale`, `mb_ad_oe`, `busy` and `done` are low. An interrupted write never reaches the PHY.
- R2: In the address phase `mb_cs_n` is low and the command address is driven (`mb_ad_oe` high). ALE stays high for ALE_CYC cycles (default 2), and the address stays driven and unchanged for HOLD_CYC cycles (default 1) after ALE falls. A PHY latching on ALE's falling edge sees the command address.
- R3: For a read, `mb_ad_oe` is low while `mb_rd_n` is low. `mb_rd_n` stays low for RD_CYC cycles (default 4), and `rd_data` returns the byte on `mb_ad_i` during the last strobe cycle.
- R4: For a write, `mb_wr_n` stays low for WR_CYC cycles (default 2) with the write byte on `mb_ad_o` and `mb_ad_oe` high. The byte is still driven, unchanged, in the cycle in which `mb_wr_n` rises.
- R5: `mb_rd_n` and `mb_wr_n` are never low together, and either strobe is low only while `mb_cs_n` is low.
- R6: A PHY reset command drives `phy_rst_n` low for exactly RST_CYC cycles (default 16). During that time `mb_cs_n` is high, `mb_ale` is low and the bus is not driven.
- R7: `busy` rises only after a command was presented, and it stays high until the cycle of `done`. Commands presented while `busy` is high are ignored: they cause no extra `done` and no bus write.
- R8: `done` is a one-cycle pulse with `busy` low. It comes 10 cycles after the accepting clock edge for a read, 8 for a write and 17 for a PHY reset (default timing).
- R9: `irq_level` follows `phy_irq` two clock edges after the input changes.
- R10: The opcode in `cmd_op` is 2'b01 for read, 2'b10 for write and 2'b11 for PHY reset. Code 2'b00 with `cmd_valid` high is ignored: `busy` stays low and no bus cycle starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command request, taken when the block is idle |
| cmd_op | input | 2 | Opcode: 01 read, 10 write, 11 PHY reset, 00 ignored |
| cmd_addr | input | 8 | Register address |
| cmd_wdata | input | 8 | Write data byte |
| busy | output | 1 | High from command acceptance until done |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte captured by the last read |
| irq_level | output | 1 | Synchronized PHY interrupt level |
| mb_cs_n | output | 1 | PHY chip select, active low |
| mb_ale | output | 1 | Address latch enable |
| mb_rd_n | output | 1 | Read strobe, active low |
| mb_wr_n | output | 1 | Write strobe, active low |
| phy_rst_n | output | 1 | PHY reset, active low |
| mb_ad_o | output | 8 | Shared bus output value |
| mb_ad_oe | output | 1 | Shared bus output enable |
| mb_ad_i | input | 8 | Shared bus input value |
| phy_irq | input | 1 | PHY interrupt input |

## Verification
With default timing, `done` appears on the 10th falling edge after the accepting rising edge for a read, the 8th for a write and the 17th for a PHY reset. The read byte is the value on the bus in the fourth strobe cycle, and `irq_level` changes on the second falling edge after the input does. The bench drives each command on a falling edge and then counts falling edges until `done`. On each of those edges it tallies ALE-high, strobe-low, reset-low and busy cycles, and it compares these tallies and the cycle count against the figures above. A behavioural PHY in the bench latches the address on ALE's falling edge and stores write data on the write strobe's rising edge. This makes data correctness visible only through later reads.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  typedef enum logic [1:0] {
    OP_NOP    = 2'b00,
    OP_READ   = 2'b01,
    OP_WRITE  = 2'b10,
    OP_PHYRST = 2'b11
  } mbus_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ALE,
    ST_HOLD,
    ST_STRB,
    ST_FIN,
    ST_PRST
  } mbus_st_e;

endpackage

// File: rtl/mbus_seq.sv
module mbus_seq
  import mbus_pkg::*;
#(
  parameter int SETUP_CYC = 1,
  parameter int ALE_CYC   = 2,
  parameter int HOLD_CYC  = 1,
  parameter int RD_CYC    = 4,
  parameter int WR_CYC    = 2,
  parameter int RST_CYC   = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cmd_valid,
  input  mbus_op_e cmd_op,
  output logic     accept,
  output logic     load_data,
  output logic     cap_en,
  output logic     oe_nxt,
  output logic     cs_n,
  output logic     ale,
  output logic     rd_n,
  output logic     wr_n,
  output logic     prst_n,
  output logic     busy,
  output logic     done
);

  localparam int M1   = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
  localparam int M2   = (M1 > RST_CYC) ? M1 : RST_CYC;
  localparam int M3   = (M2 > ALE_CYC) ? M2 : ALE_CYC;
  localparam int M4   = (M3 > SETUP_CYC) ? M3 : SETUP_CYC;
  localparam int MAXC = (M4 > HOLD_CYC) ? M4 : HOLD_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  localparam logic [CW-1:0] L_SETUP = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] L_ALE   = CW'(ALE_CYC - 1);
  localparam logic [CW-1:0] L_HOLD  = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] L_RD    = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] L_WR    = CW'(WR_CYC - 1);
  localparam logic [CW-1:0] L_RST   = CW'(RST_CYC - 1);

  mbus_st_e      st_q, st_nxt;
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          is_rd_q, is_rd_nxt;
  logic          fin;

  always_comb begin
    st_nxt    = st_q;
    cnt_nxt   = cnt_q;
    is_rd_nxt = is_rd_q;
    accept    = 1'b0;
    fin       = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (cmd_valid && (cmd_op != OP_NOP)) begin
          accept = 1'b1;
          if (cmd_op == OP_PHYRST) begin
            st_nxt  = ST_PRST;
            cnt_nxt = L_RST;
          end else begin
            st_nxt    = ST_SETUP;
            cnt_nxt   = L_SETUP;
            is_rd_nxt = (cmd_op == OP_READ);
          end
        end
      end
      default: begin
        if (cnt_q != '0) begin
          cnt_nxt = cnt_q - CW'(1);
        end else begin
          case (st_q)
            ST_SETUP: begin st_nxt = ST_ALE;  cnt_nxt = L_ALE;  end
            ST_ALE:   begin st_nxt = ST_HOLD; cnt_nxt = L_HOLD; end
            ST_HOLD: begin
              st_nxt  = ST_STRB;
              cnt_nxt = is_rd_q ? L_RD : L_WR;
            end
            ST_STRB:  begin st_nxt = ST_FIN;  cnt_nxt = '0;     end
            default: begin
              st_nxt = ST_IDLE;
              fin    = 1'b1;
            end
          endcase
        end
      end
    endcase
  end

  // Strobe-edge enables for the datapath
  assign cap_en    = (st_q == ST_STRB) && (cnt_q == '0) && is_rd_q;
  assign load_data = (st_q == ST_HOLD) && (cnt_q == '0) && !is_rd_q;

  // Pin values for the next cycle, registered below to keep pins glitch-free
  logic cs_n_nxt, ale_nxt, rd_n_nxt, wr_n_nxt, prst_n_nxt, busy_nxt;

  always_comb begin
    cs_n_nxt   = !(st_nxt inside {ST_SETUP, ST_ALE, ST_HOLD, ST_STRB, ST_FIN});
    ale_nxt    = (st_nxt == ST_ALE);
    rd_n_nxt   = !((st_nxt == ST_STRB) && is_rd_nxt);
    wr_n_nxt   = !((st_nxt == ST_STRB) && !is_rd_nxt);
    prst_n_nxt = (st_nxt != ST_PRST);
    busy_nxt   = (st_nxt != ST_IDLE);
    oe_nxt     = (st_nxt inside {ST_SETUP, ST_ALE, ST_HOLD}) ||
                 (!is_rd_nxt && (st_nxt inside {ST_STRB, ST_FIN}));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      is_rd_q <= 1'b0;
      cs_n    <= 1'b1;
      ale     <= 1'b0;
      rd_n    <= 1'b1;
      wr_n    <= 1'b1;
      prst_n  <= 1'b1;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      st_q    <= st_nxt;
      cnt_q   <= cnt_nxt;
      is_rd_q <= is_rd_nxt;
      cs_n    <= cs_n_nxt;
      ale     <= ale_nxt;
      rd_n    <= rd_n_nxt;
      wr_n    <= wr_n_nxt;
      prst_n  <= prst_n_nxt;
      busy    <= busy_nxt;
      done    <= fin;
    end
  end

endmodule

// File: rtl/mbus_dpath.sv
module mbus_dpath #(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             load_data,
  input  logic             cap_en,
  input  logic             oe_nxt,
  input  logic [BUS_W-1:0] cmd_addr,
  input  logic [BUS_W-1:0] cmd_wdata,
  input  logic [BUS_W-1:0] ad_i,
  output logic [BUS_W-1:0] ad_o,
  output logic             ad_oe,
  output logic [BUS_W-1:0] rd_data
);

  logic [BUS_W-1:0] wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdata_q <= '0;
      ad_o    <= '0;
      ad_oe   <= 1'b0;
      rd_data <= '0;
    end else begin
      ad_oe <= oe_nxt;
      if (accept) begin
        ad_o    <= cmd_addr;
        wdata_q <= cmd_wdata;
      end else if (load_data) begin
        ad_o <= wdata_q;
      end
      if (cap_en) begin
        rd_data <= ad_i;
      end
    end
  end

endmodule

// File: rtl/mbus_irq_sync.sv
module mbus_irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_in,
  output logic irq_out
);

  logic [STAGES-1:0] sync_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= irq_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= 1'b0;
        else        sync_q[g] <= sync_q[g-1];
      end
    end
  end

  assign irq_out = sync_q[STAGES-1];

endmodule

// File: rtl/phy_mbus_master.sv
module phy_mbus_master
  import mbus_pkg::*;
#(
  parameter int BUS_W      = 8,
  parameter int SETUP_CYC  = 1,
  parameter int ALE_CYC    = 2,
  parameter int HOLD_CYC   = 1,
  parameter int RD_CYC     = 4,
  parameter int WR_CYC     = 2,
  parameter int RST_CYC    = 16,
  parameter int IRQ_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [BUS_W-1:0] cmd_addr,
  input  logic [BUS_W-1:0] cmd_wdata,
  output logic             busy,
  output logic             done,
  output logic [BUS_W-1:0] rd_data,
  output logic             irq_level,
  output logic             mb_cs_n,
  output logic             mb_ale,
  output logic             mb_rd_n,
  output logic             mb_wr_n,
  output logic             phy_rst_n,
  output logic [BUS_W-1:0] mb_ad_o,
  output logic             mb_ad_oe,
  input  logic [BUS_W-1:0] mb_ad_i,
  input  logic             phy_irq
);

  // Reset: asserted asynchronously, released on the second clock edge
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic accept, load_data, cap_en, oe_nxt;

  mbus_seq #(
    .SETUP_CYC(SETUP_CYC), .ALE_CYC(ALE_CYC), .HOLD_CYC(HOLD_CYC),
    .RD_CYC(RD_CYC), .WR_CYC(WR_CYC), .RST_CYC(RST_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (mbus_op_e'(cmd_op)),
    .accept    (accept),
    .load_data (load_data),
    .cap_en    (cap_en),
    .oe_nxt    (oe_nxt),
    .cs_n      (mb_cs_n),
    .ale       (mb_ale),
    .rd_n      (mb_rd_n),
    .wr_n      (mb_wr_n),
    .prst_n    (phy_rst_n),
    .busy      (busy),
    .done      (done)
  );

  mbus_dpath #(.BUS_W(BUS_W)) u_dpath (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .accept    (accept),
    .load_data (load_data),
    .cap_en    (cap_en),
    .oe_nxt    (oe_nxt),
    .cmd_addr  (cmd_addr),
    .cmd_wdata (cmd_wdata),
    .ad_i      (mb_ad_i),
    .ad_o      (mb_ad_o),
    .ad_oe     (mb_ad_oe),
    .rd_data   (rd_data)
  );

  mbus_irq_sync #(.STAGES(IRQ_STAGES)) u_irq (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .irq_in  (phy_irq),
    .irq_out (irq_level)
  );

endmodule

// File: rtl/mbus_master_chk.sv
module mbus_master_chk #(
  parameter int BUS_W   = 8,
  parameter int ALE_CYC = 2,
  parameter int RD_CYC  = 4,
  parameter int WR_CYC  = 2,
  parameter int RST_CYC = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cs_n,
  input logic             ale,
  input logic             rd_n,
  input logic             wr_n,
  input logic             prst_n,
  input logic             ad_oe,
  input logic [BUS_W-1:0] ad_o,
  input logic             busy,
  input logic             done
);

  logic [15:0] ale_hi, rd_lo, wr_lo, prst_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_hi  <= '0;
      rd_lo   <= '0;
      wr_lo   <= '0;
      prst_lo <= '0;
    end else begin
      ale_hi  <= ale     ? ale_hi + 16'd1  : 16'd0;
      rd_lo   <= !rd_n   ? rd_lo + 16'd1   : 16'd0;
      wr_lo   <= !wr_n   ? wr_lo + 16'd1   : 16'd0;
      prst_lo <= !prst_n ? prst_lo + 16'd1 : 16'd0;
    end
  end

  p_ale_drv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (ad_oe && !cs_n));
  p_ale_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> (ad_oe && !cs_n && $stable(ad_o)));
  p_ale_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> (ale_hi == 16'(ALE_CYC)));
  p_rd_float_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);
  p_rd_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_n) |-> (rd_lo == 16'(RD_CYC)));
  p_wr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> (ad_oe && $stable(ad_o)));
  p_wr_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> (wr_lo == 16'(WR_CYC)));
  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
  p_strobe_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> !cs_n);
  p_prst_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !prst_n |-> (cs_n && !ale && !ad_oe));
  p_prst_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prst_n) |-> (prst_lo == 16'(RST_CYC)));
  p_busy_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid));
  p_busy_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

bind phy_mbus_master mbus_master_chk #(
  .BUS_W(BUS_W), .ALE_CYC(ALE_CYC), .RD_CYC(RD_CYC),
  .WR_CYC(WR_CYC), .RST_CYC(RST_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .cmd_valid (cmd_valid),
  .cs_n      (mb_cs_n),
  .ale       (mb_ale),
  .rd_n      (mb_rd_n),
  .wr_n      (mb_wr_n),
  .prst_n    (phy_rst_n),
  .ad_oe     (mb_ad_oe),
  .ad_o      (mb_ad_o),
  .busy      (busy),
  .done      (done)
);

// File: tb/phy_mbus_master_tb.sv
module phy_mbus_master_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid;
  logic [1:0] cmd_op;
  logic [7:0] cmd_addr, cmd_wdata;
  logic       busy, done, irq_level;
  logic [7:0] rd_data;
  logic       mb_cs_n, mb_ale, mb_rd_n, mb_wr_n, phy_rst_n, mb_ad_oe;
  logic [7:0] mb_ad_o, mb_ad_i;
  logic       phy_irq;

  always #5 clk = ~clk;

  phy_mbus_master u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
    .rd_data(rd_data), .irq_level(irq_level), .mb_cs_n(mb_cs_n),
    .mb_ale(mb_ale), .mb_rd_n(mb_rd_n), .mb_wr_n(mb_wr_n),
    .phy_rst_n(phy_rst_n), .mb_ad_o(mb_ad_o), .mb_ad_oe(mb_ad_oe),
    .mb_ad_i(mb_ad_i), .phy_irq(phy_irq)
  );

  // Behavioural PHY: address on ALE fall, write data on write-strobe rise
  logic [7:0] phy_mem [256];
  logic [7:0] phy_lat;

  always @(negedge mb_ale) phy_lat = mb_ad_o;
  always @(posedge mb_wr_n) if (rst_n === 1'b1 && mb_ad_oe === 1'b1) phy_mem[phy_lat] = mb_ad_o;
  assign mb_ad_i = (!mb_rd_n && !mb_cs_n) ? phy_mem[phy_lat] : 8'hEE;

  int checks = 0;
  int errors = 0;
  int cyc, ale_n, rdl, wrl, prl, busy_n, wr_bad;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Presents one command, then counts falling edges until done
  task automatic run_cmd(input logic [1:0] op, input logic [7:0] a, input logic [7:0] wd);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b00;
    cyc = 1; ale_n = 0; rdl = 0; wrl = 0; prl = 0; busy_n = 0; wr_bad = 0;
    while (!done && cyc < 60) begin
      if (mb_ale) ale_n++;
      if (!mb_rd_n) rdl++;
      if (!mb_wr_n) begin
        wrl++;
        if (mb_ad_o !== wd || mb_ad_oe !== 1'b1) wr_bad++;
      end
      if (!phy_rst_n) prl++;
      if (busy) busy_n++;
      @(negedge clk);
      cyc++;
    end
  endtask

  typedef struct packed {
    logic [1:0] op;
    logic [7:0] addr;
    logic [7:0] wd;
    logic [7:0] exp;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{2'b10, 8'h10, 8'hA5, 8'h00},
    '{2'b10, 8'hFF, 8'h3C, 8'h00},
    '{2'b01, 8'h10, 8'h00, 8'hA5},
    '{2'b01, 8'hFF, 8'h00, 8'h3C},
    '{2'b01, 8'h00, 8'h00, 8'h5A},
    '{2'b10, 8'h00, 8'h00, 8'h00},
    '{2'b01, 8'h00, 8'h00, 8'h00},
    '{2'b01, 8'h80, 8'h00, 8'hDA},
    '{2'b10, 8'h10, 8'hFF, 8'h00},
    '{2'b01, 8'h10, 8'h00, 8'hFF}
  };

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) phy_mem[i] = 8'(i) ^ 8'h5A;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'b00;
    cmd_addr = 8'h00; cmd_wdata = 8'h00; phy_irq = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset pins cs/rd/wr/prst", {28'd0, mb_cs_n, mb_rd_n, mb_wr_n, phy_rst_n}, 32'hF);
    chk("R1 reset ale/oe/busy/done", {28'd0, mb_ale, mb_ad_oe, busy, done}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Vector table: R2 R3 R4 R7 R8
    for (int i = 0; i < 10; i++) begin
      run_cmd(VEC[i].op, VEC[i].addr, VEC[i].wd);
      chk("R2 latched address", {24'd0, phy_lat}, {24'd0, VEC[i].addr});
      chk("R2 ale width", ale_n, 2);
      chk("R7 busy until done", busy_n, cyc - 1);
      chk("R8 busy low at done", {31'd0, busy}, 0);
      if (VEC[i].op == 2'b01) begin
        chk("R8 read done latency", cyc, 10);
        chk("R3 read strobe width", rdl, 4);
        chk("R3 read data", {24'd0, rd_data}, {24'd0, VEC[i].exp});
        chk("R5 no write strobe in read", wrl, 0);
      end else begin
        chk("R8 write done latency", cyc, 8);
        chk("R4 write strobe width", wrl, 2);
        chk("R4 write data on bus", wr_bad, 0);
        chk("R5 no read strobe in write", rdl, 0);
      end
      @(negedge clk);
      chk("R8 done single cycle", {31'd0, done}, 0);
    end

    // R6 PHY reset command
    run_cmd(2'b11, 8'h00, 8'h00);
    chk("R6 reset done latency", cyc, 17);
    chk("R6 phy reset width", prl, 16);
    chk("R6 bus idle during reset", ale_n + rdl + wrl, 0);
    chk("R6 cs high after", {31'd0, mb_cs_n}, 1);

    // R7 command during busy is ignored
    begin
      int dones;
      dones = 0;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 2'b01; cmd_addr = 8'h10;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 2'b00;
      repeat (2) @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 2'b10; cmd_addr = 8'h10; cmd_wdata = 8'h77;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 2'b00;
      for (int k = 0; k < 20; k++) begin
        if (done) dones++;
        @(negedge clk);
      end
      chk("R7 one done for busy-time command", dones, 1);
      chk("R7 read data unaffected", {24'd0, rd_data}, 32'hFF);
      run_cmd(2'b01, 8'h10, 8'h00);
      chk("R7 ignored write left register", {24'd0, rd_data}, 32'hFF);
    end

    // R10 no-operation code ignored
    begin
      int act;
      act = 0;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 2'b00; cmd_addr = 8'h33;
      @(negedge clk);
      cmd_valid = 1'b0;
      for (int k = 0; k < 4; k++) begin
        if (busy || done || !mb_cs_n || mb_ad_oe) act++;
        @(negedge clk);
      end
      chk("R10 nop ignored", act, 0);
    end

    // R9 interrupt synchronization
    phy_irq = 1'b1;
    @(negedge clk);
    chk("R9 irq after one edge", {31'd0, irq_level}, 0);
    @(negedge clk);
    chk("R9 irq after two edges", {31'd0, irq_level}, 1);
    phy_irq = 1'b0;
    @(negedge clk);
    chk("R9 irq clear after one edge", {31'd0, irq_level}, 1);
    @(negedge clk);
    chk("R9 irq clear after two edges", {31'd0, irq_level}, 0);

    // R1 asynchronous reset in the middle of a write
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b10; cmd_addr = 8'h20; cmd_wdata = 8'h99;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b00;
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 mid reset pins cs/rd/wr/prst", {28'd0, mb_cs_n, mb_rd_n, mb_wr_n, phy_rst_n}, 32'hF);
    chk("R1 mid reset ale/oe/busy/done", {28'd0, mb_ale, mb_ad_oe, busy, done}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_cmd(2'b01, 8'h20, 8'h00);
    chk("R1 aborted write not stored", {24'd0, rd_data}, 32'h7A);
    chk("R8 read latency after reset", cyc, 10);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule